// File: doc/BRIEF.md
# Multi-View Counting Semaphore Cell

The block is a single 16-bit counting semaphore that several requesters share through a memory-mapped load/store port. Each requester has its own valid/ready handshake. A two-bit address field on each request selects how the access treats the cell.

In the blocking P/V view, a load consumes one unit of the count. In the non-blocking P/V view, a load does the same but never waits. The raw view reads or overwrites the count with no side effect. The tag view reads or writes a small status word. A load that must wait for a unit holds that requester's ready low. The waiting requester does not prevent the other requesters from using the cell, so one of them can post the unit the waiter needs.

At most one request completes per cycle. Load data appears on a shared read bus in the cycle the handshake completes.

Top module: `semcell_top`

## Requirements
- R1: After synchronous active-low reset the count is 0, and the tag word reads 0.
- R2: The two-bit address field of a request selects the view: 2'b00 raw, 2'b01 tag, 2'b10 blocking P/V, 2'b11 non-blocking P/V.
- R3: A P/V-view load (blocking or non-blocking) with a nonzero count returns the count on `rsp_rdata` in the handshake cycle and lowers the count by one.
- R4: A P/V-view store raises the count by one and saturates at 16'hFFFF; the store data has no effect on the result.
- R5: A blocking P/V load while the count is 0 keeps that requester's ready low and leaves the count unchanged.
- R6: A blocking load stalled at zero completes in the cycle after a store makes the count nonzero: ready goes high, the load returns the new count, and the count is lowered by one at that edge.
- R7: A non-blocking P/V load with count 0 completes at once, returns 0 and leaves the count at 0.
- R8: A raw-view load returns the count and leaves it unchanged; a raw-view store writes the store data into the count. Neither one stalls.
- R9: A tag-view access never stalls. The tag word has the empty flag at bit 0 and the full flag at bit 1. Bit 2 is the read-only FIFO-kind bit, which reads 0 and ignores writes. Bits 15:3 read 0. A tag store loads bits 1:0 from the store data.
- R10: P/V-view loads and stores leave the empty and full flags unchanged.
- R11: Among the requests that can complete, the lowest-numbered port wins and is the only one given ready in that cycle. A stalled blocking load takes no part in this selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NPORT | Per-port request valid |
| req_write | input | NPORT | Per-port store (1) or load (0) |
| req_addr | input | 2*NPORT | Per-port view-select address field, port i at bits [2i+1:2i] |
| req_wdata | input | DATA_W*NPORT | Per-port store data, port i at bits [DATA_W*i +: DATA_W] |
| req_ready | output | NPORT | Per-port ready; a request completes when valid and ready are both high |
| rsp_rdata | output | DATA_W | Load data for the port that completes in the current cycle |

## Verification
The hardest state to reach is a blocking load parked on an empty count while a second requester acts on the cell. The bench holds port 0 in a blocking load at count zero over several cycles. During that wait, port 1 first reads the cell through the raw view and then posts a P/V store. The bench then checks that port 0 completes in exactly the next cycle with the value 1 and that the count returns to zero. Every view and both directions are also swept over count values at the zero and saturation boundaries, and the results are compared against arithmetic expectations.

// File: rtl/semcell_pkg.sv
// Shared definitions for the semaphore cell: view codes and tag bit positions.
package semcell_pkg;
    typedef enum logic [1:0] {
        VW_RAW  = 2'b00,
        VW_TAG  = 2'b01,
        VW_WAIT = 2'b10,
        VW_POLL = 2'b11
    } view_e;

    localparam int TAG_EMPTY_BIT = 0;
    localparam int TAG_FULL_BIT  = 1;
    localparam int TAG_KIND_BIT  = 2;
endpackage

// File: rtl/semcell_elig.sv
// Per-port eligibility decode.
// A request is eligible unless it is a blocking P/V load that meets a zero count.
// Assumes the address field is already the two-bit view code.
module semcell_elig #(
    parameter int NPORT = 2
) (
    input  logic [NPORT-1:0]   req_valid,
    input  logic [NPORT-1:0]   req_write,
    input  logic [2*NPORT-1:0] req_addr,
    input  logic               count_zero,
    output logic [NPORT-1:0]   eligible
);
    import semcell_pkg::*;

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        logic blocked;
        // A blocking load waits while no unit is available
        assign blocked     = !req_write[i] && (view_e'(req_addr[2*i +: 2]) == VW_WAIT) && count_zero;
        assign eligible[i] = req_valid[i] && !blocked;
    end
endmodule

// File: rtl/semcell_arb.sv
// Fixed-priority grant: the lowest-index eligible port wins, so at most one grant is issued per cycle.
// Purely combinational.
module semcell_arb #(
    parameter int NPORT = 2
) (
    input  logic [NPORT-1:0] eligible,
    output logic [NPORT-1:0] grant
);
    for (genvar i = 0; i < NPORT; i++) begin : g_pri
        if (i == 0) begin : g_first
            // Port 0 always wins when eligible
            assign grant[i] = eligible[i];
        end else begin : g_rest
            // Higher ports win only when every lower port is idle
            assign grant[i] = eligible[i] && !(|eligible[i-1:0]);
        end
    end
endmodule

// File: rtl/semcell_count.sv
// Count register of the cell.
// P/V loads decrement with a floor at zero, P/V stores increment with saturation, and raw stores overwrite.
// Assumes fire marks the single completing request.
module semcell_count #(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire,
    input  logic                is_write,
    input  semcell_pkg::view_e  view,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   count,
    output logic                count_zero
);
    import semcell_pkg::*;

    localparam logic [DATA_W-1:0] CNT_MAX = {DATA_W{1'b1}};

    logic [DATA_W-1:0] count_nxt;

    assign count_zero = (count == '0);

    // Next-count selection for the completing request
    always_comb begin
        count_nxt = count;
        if (fire) begin
            case (view)
                VW_RAW:  if (is_write) count_nxt = wdata;
                VW_WAIT,
                VW_POLL: begin
                    if (is_write) count_nxt = (count == CNT_MAX) ? count : count + 1'b1;
                    else          count_nxt = count_zero ? count : count - 1'b1;
                end
                default: count_nxt = count;
            endcase
        end
    end

    // Count register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count_nxt;
    end

    AST_PV_LOAD_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !is_write && (view == VW_WAIT || view == VW_POLL) && !count_zero
        |=> count == $past(count) - 1'b1) else $error("pv load decrement"); // R3

    AST_PV_STORE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        fire && is_write && (view == VW_WAIT || view == VW_POLL) && count == CNT_MAX
        |=> count == CNT_MAX) else $error("pv store saturation"); // R4

    AST_POLL_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !is_write && view == VW_POLL && count_zero
        |=> count_zero) else $error("poll at zero"); // R7

    AST_RAW_LOAD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !is_write && view == VW_RAW
        |=> $stable(count)) else $error("raw load side effect"); // R8
endmodule

// File: rtl/semcell_tag.sv
// Tag register of the cell.
// Holds the empty and full flags, which only a tag-view store changes.
// The FIFO-kind bit reads as 0 because this cell is a semaphore.
module semcell_tag #(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire,
    input  logic                is_write,
    input  semcell_pkg::view_e  view,
    input  logic [1:0]          wflags,
    output logic [DATA_W-1:0]   tag_word
);
    import semcell_pkg::*;

    logic [1:0] flags;

    // Flag register: written only by tag-view stores
    always_ff @(posedge clk) begin
        if (!rst_n)                                   flags <= '0;
        else if (fire && is_write && view == VW_TAG)  flags <= wflags;
    end

    // Readback word assembly; the kind bit and the upper bits are zero
    always_comb begin
        tag_word                = '0;
        tag_word[TAG_EMPTY_BIT] = flags[0];
        tag_word[TAG_FULL_BIT]  = flags[1];
        tag_word[TAG_KIND_BIT]  = 1'b0;
    end

    AST_PV_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        fire && (view == VW_WAIT || view == VW_POLL)
        |=> $stable(flags)) else $error("pv op touched flags"); // R10
endmodule

// File: rtl/semcell_top.sv
// Multi-view counting semaphore cell shared by NPORT requesters.
// It picks one completing request per cycle, applies it to the count or the tag, and returns load data on a shared bus.
// Assumes requesters hold their request until ready is seen.
module semcell_top #(
    parameter int NPORT  = 2,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT-1:0]        req_valid,
    input  logic [NPORT-1:0]        req_write,
    input  logic [2*NPORT-1:0]      req_addr,
    input  logic [DATA_W*NPORT-1:0] req_wdata,
    output logic [NPORT-1:0]        req_ready,
    output logic [DATA_W-1:0]       rsp_rdata
);
    import semcell_pkg::*;

    logic [NPORT-1:0]  eligible;
    logic [NPORT-1:0]  grant;
    logic              count_zero;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] tag_word;
    logic              fire;
    logic              sel_write;
    logic [1:0]        sel_view_raw;
    view_e             sel_view;
    logic [DATA_W-1:0] sel_wdata;

    semcell_elig #(.NPORT(NPORT)) u_elig (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .count_zero(count_zero),
        .eligible  (eligible)
    );

    semcell_arb #(.NPORT(NPORT)) u_arb (
        .eligible(eligible),
        .grant   (grant)
    );

    // Collect the fields of the single granted request
    always_comb begin
        sel_write    = 1'b0;
        sel_view_raw = '0;
        sel_wdata    = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (grant[i]) begin
                sel_write    = sel_write    | req_write[i];
                sel_view_raw = sel_view_raw | req_addr[2*i +: 2];
                sel_wdata    = sel_wdata    | req_wdata[DATA_W*i +: DATA_W];
            end
        end
    end

    assign sel_view  = view_e'(sel_view_raw);
    assign fire      = |grant;
    assign req_ready = grant;

    semcell_count #(.DATA_W(DATA_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .is_write  (sel_write),
        .view      (sel_view),
        .wdata     (sel_wdata),
        .count     (count),
        .count_zero(count_zero)
    );

    semcell_tag #(.DATA_W(DATA_W)) u_tag (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .is_write(sel_write),
        .view    (sel_view),
        .wflags  (sel_wdata[1:0]),
        .tag_word(tag_word)
    );

    // Load data: the tag word in the tag view, the count in every other view
    assign rsp_rdata = (sel_view == VW_TAG) ? tag_word : count;

    AST_ONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready)) else $error("more than one ready"); // R11

    for (genvar i = 0; i < NPORT; i++) begin : g_chk
        AST_WAIT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[i] && !req_write[i] && req_addr[2*i +: 2] == 2'b10 && count == '0
            |-> !req_ready[i]) else $error("blocking load not stalled"); // R5
    end
endmodule

// File: tb/semcell_top_tb.sv
// Self-checking bench for semcell_top with two ports.
module semcell_top_tb;
    localparam int NP = 2;
    localparam int DW = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NP-1:0]  req_valid = '0;
    logic [NP-1:0]  req_write = '0;
    logic [2*NP-1:0] req_addr = '0;
    logic [DW*NP-1:0] req_wdata = '0;
    logic [NP-1:0]  req_ready;
    logic [DW-1:0]  rsp_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    semcell_top #(.NPORT(NP), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input int p, input bit w, input logic [1:0] vw, input logic [15:0] d);
        req_valid[p]            = 1'b1;
        req_write[p]            = w;
        req_addr[2*p +: 2]      = vw;
        req_wdata[DW*p +: DW]   = d;
    endtask

    // One request, returns ready and read data sampled before the edge
    task automatic issue(input int p, input bit w, input logic [1:0] vw, input logic [15:0] d,
                         output logic rdy, output logic [15:0] rd);
        @(negedge clk);
        drive(p, w, vw, d);
        #1;
        rdy = req_ready[p];
        rd  = rsp_rdata;
        @(posedge clk);
        #1;
        req_valid[p] = 1'b0;
    endtask

    task automatic read_count(input int p, output logic [15:0] c);
        logic r;
        issue(p, 1'b0, 2'b00, 16'h0, r, c);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected 0", cycles);
            finish_run();
        end
    end

    initial begin
        logic        rdy;
        logic [15:0] rd, c, d, exp_c, exp_rd;
        logic [1:0]  flags;
        logic [15:0] vals [6];
        vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'hFFFE, 16'hFFFF};
        flags = 2'b00;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state through raw and tag views
        read_count(0, c);
        check(c == 16'h0, "R1 count", c, 0);
        issue(0, 1'b0, 2'b01, 16'h0, rdy, rd);
        check(rdy && rd == 16'h0, "R1 tag", rd, 0);

        // R2/R3/R4/R5/R7/R8/R10 sweep: every view and direction over boundary counts
        for (int k = 0; k < 6; k++) begin
            for (int vw = 0; vw < 4; vw++) begin
                for (int w = 0; w < 2; w++) begin
                    int p;
                    p = (k + vw) % 2;
                    issue(0, 1'b1, 2'b00, vals[k], rdy, rd);
                    d = vals[k] ^ 16'h5A5A ^ 16'(vw * 7);
                    issue(p, w[0], vw[1:0], d, rdy, rd);
                    exp_c  = vals[k];
                    exp_rd = vals[k];
                    case (vw)
                        0: if (w) exp_c = d;
                        1: begin
                            if (w) flags = d[1:0];
                            else exp_rd = {14'h0, flags};
                        end
                        default: begin
                            if (w) exp_c = (vals[k] == 16'hFFFF) ? 16'hFFFF : vals[k] + 1;
                            else   exp_c = (vals[k] == 16'h0) ? 16'h0 : vals[k] - 1;
                        end
                    endcase
                    if (vw == 2 && !w && vals[k] == 16'h0) begin
                        check(!rdy, "R5 stall ready", {31'h0, rdy}, 0);
                    end else begin
                        check(rdy, "R2 ready", {31'h0, rdy}, 1);
                        if (!w) check(rd == exp_rd, vw >= 2 ? (vals[k] == 0 ? "R7 read" : "R3 read") : (vw == 0 ? "R8 read" : "R9 read"), rd, exp_rd);
                    end
                    read_count(1 - p, c);
                    check(c == exp_c, vw >= 2 ? (w ? "R4 count" : "R3 count") : "R8 count", c, exp_c);
                end
            end
            // R10: flags survive all P/V operations of this round
            issue(0, 1'b0, 2'b01, 16'h0, rdy, rd);
            check(rd == {14'h0, flags}, "R10 flags", rd, {14'h0, flags});
        end

        // R9: tag writes, kind bit and upper bits stay zero
        for (int t = 0; t < 8; t++) begin
            d = {13'h1FFF, t[2:0]};
            issue(t % 2, 1'b1, 2'b01, d, rdy, rd);
            check(rdy, "R9 store ready", {31'h0, rdy}, 1);
            issue(0, 1'b0, 2'b01, 16'h0, rdy, rd);
            check(rd == {14'h0, t[1:0]}, "R9 tag read", rd, {14'h0, t[1:0]});
        end

        // R4: saturation with repeated stores
        issue(0, 1'b1, 2'b00, 16'hFFFD, rdy, rd);
        for (int n = 0; n < 4; n++) issue(1, 1'b1, 2'b11, 16'h0, rdy, rd);
        read_count(0, c);
        check(c == 16'hFFFF, "R4 saturate", c, 16'hFFFF);

        // R11: both ports valid, lowest index wins
        issue(0, 1'b1, 2'b00, 16'h0003, rdy, rd);
        @(negedge clk);
        drive(0, 1'b0, 2'b00, 16'h0);
        drive(1, 1'b0, 2'b00, 16'h0);
        #1;
        check(req_ready == 2'b01, "R11 priority", {30'h0, req_ready}, 1);
        @(posedge clk);
        #1 req_valid = '0;

        // R5/R6/R11: port 0 blocked at zero while port 1 works
        issue(0, 1'b1, 2'b00, 16'h0, rdy, rd);
        @(negedge clk);
        drive(0, 1'b0, 2'b10, 16'h0);
        for (int s = 0; s < 3; s++) begin
            #1;
            check(!req_ready[0], "R5 held stall", {31'h0, req_ready[0]}, 0);
            @(negedge clk);
        end
        drive(1, 1'b0, 2'b00, 16'h0);
        #1;
        check(req_ready == 2'b10 && rsp_rdata == 16'h0, "R11 bypass of stalled port", {14'h0, req_ready, rsp_rdata}, {16'h2, 16'h0});
        @(negedge clk);
        drive(1, 1'b1, 2'b10, 16'h1234);
        #1;
        check(req_ready == 2'b10, "R6 store granted", {30'h0, req_ready}, 2);
        @(negedge clk);
        req_valid[1] = 1'b0;
        #1;
        check(req_ready[0] && rsp_rdata == 16'h1, "R6 wake", {15'h0, req_ready[0], rsp_rdata}, {16'h1, 16'h1});
        @(negedge clk);
        req_valid[0] = 1'b0;
        read_count(1, c);
        check(c == 16'h0, "R6 count after wake", c, 0);

        finish_run();
    end
endmodule